// File: doc/BRIEF.md
# Four-Rail Power Sequencer with Power-Good Reset

This block turns a set of regulator rails on and off in a programmable order and drives an active-low system reset that doubles as a power-good indication. Each rail gets a slot number from a configuration bus. A power-up request switches on the wanted rails one slot at a time, with a fixed wait between slots. It then waits for every enabled rail to clear its undervoltage comparator and releases reset. A power-down request switches the rails off in the opposite slot order with the same spacing.

In the steady on state, the block watches the window comparators of the rails that are enabled. The comparators of disabled rails are ignored. A voltage-change-in-progress input suppresses the window check while a rail is being moved to a new level. A mode switch loads a new enable mask. Rails that are newly wanted are turned on at once, and rails that are no longer wanted stay on until every newly enabled rail reports good. A watchdog-expired input, when the watchdog is enabled, pulls reset low in any state.

If rails do not come good within a timeout, the block raises a sticky fault and runs the power-down order. Requests that arrive while a sequence is running are dropped, and a busy output shows when that is the case.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, all rail enables are 0, `sys_rst_n` is 0, and `busy` and `seq_fault` are 0.
- R2: Field r of `pos_cfg` (bits 2r+1:2r) is the slot of rail r, with 0 as the first slot. An accepted power-up request turns on the wanted rails (from `tgt_en`) of slot 0 at the next clock edge. Each later slot follows STEP_CYC cycles after the one before it, and rails are never turned off during power-up.
- R3: Power-down turns off the rails of slot 3 first and then slots 2, 1 and 0, one slot every STEP_CYC cycles. No rail turns on during power-down, and the block returns to off with all enables 0.
- R4: `sys_rst_n` is registered and shows the previous cycle's condition. It is 0 while the block is off, powering up, waiting for good, or powering down. It goes to 1 one cycle after the power-up wait sees no enabled rail below 90%.
- R5: In the steady on state, an enabled rail below 90% (`uv`) or above 110% (`ov`) drives `sys_rst_n` to 0 one cycle later. Comparator inputs of rails whose enable is 0 have no effect.
- R6: While `vchg` is 1, window excursions of enabled rails do not pull `sys_rst_n` low.
- R7: On an accepted mode switch, the rails in the new mask are on one cycle later. Rails leaving the mask stay on until no newly enabled rail shows `uv`, and only then are they turned off. `sys_rst_n` is not pulled low by the switch.
- R8: `wd_en` and `wd_exp` both at 1 drive `sys_rst_n` to 0 one cycle later in any state. The low level is released one cycle after the condition goes away. `wd_exp` alone has no effect.
- R9: Power-up requests are accepted only in the off state. Power-down requests and mode switches are accepted only in the steady on state. `busy` is 1 during power-up, the wait for good, a mode switch and power-down.
- R10: If the enabled rails are not all good within TMO_CYC cycles of the power-up wait, or the newly enabled rails are not all good within TMO_CYC cycles of a mode switch, `seq_fault` is set and power-down starts. The next accepted power-up request clears the fault.
- R11: A power-down request and a mode switch arriving in the same cycle in the on state start power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_cfg | input | NRAIL*PW (8) | Slot number of each rail, PW bits per rail |
| tgt_en | input | NRAIL (4) | Wanted enable mask for power-up and mode switch |
| up_req | input | 1 | Power-up request pulse |
| down_req | input | 1 | Power-down request pulse |
| mode_sw | input | 1 | Mode switch request pulse, loads `tgt_en` |
| uv | input | NRAIL (4) | Rail below 90% of target |
| ov | input | NRAIL (4) | Rail above 110% of target |
| vchg | input | 1 | On-the-fly voltage change in progress |
| wd_en | input | 1 | Watchdog enabled |
| wd_exp | input | 1 | Watchdog expired |
| rail_en | output | NRAIL (4) | Regulator enables |
| sys_rst_n | output | 1 | Active-low system reset / power good |
| busy | output | 1 | A sequence or mode switch is running |
| seq_fault | output | 1 | Sticky timeout fault |

## Verification
The hardest situation to reach is a mode switch that stalls: a rail that is newly enabled never clears undervoltage while a rail that is leaving must stay on, and the stall has to last long enough to time out into power-down. The bench models each regulator as a ramp that clears `uv` a few cycles after its enable. It can pin any rail's `uv` high, which creates both the stalled swap and the stalled power-up wait. A cycle-accurate reference model follows every state. Pulses of `uv`, `ov` and watchdog are placed on enabled and disabled rails in the on state to separate masking from window detection.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

   typedef enum logic [2:0] {
      SQ_OFF    = 3'd0,
      SQ_RISE   = 3'd1,
      SQ_SETTLE = 3'd2,
      SQ_ON     = 3'd3,
      SQ_SWAP   = 3'd4,
      SQ_FALL   = 3'd5
   } seq_st_e;

   function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m < 2) ? 1 : $clog2(m + 1);
   endfunction

endpackage

// File: rtl/rail_seq_posdec.sv
module rail_seq_posdec #(
   parameter int unsigned NRAIL = 4,
   parameter int unsigned PW    = 2
) (
   input  logic [NRAIL*PW-1:0]          pos_cfg,
   output logic [NRAIL-1:0][NRAIL-1:0]  pos_mask
);

   // pos_mask[slot][rail] is 1 when that rail is assigned to that slot
   for (genvar k = 0; k < NRAIL; k++) begin : g_slot
      for (genvar r = 0; r < NRAIL; r++) begin : g_rail
         assign pos_mask[k][r] = (pos_cfg[r*PW +: PW] == PW'(k));
      end
   end

endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= cnt + CW'(1);
      end
   end

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
   import rail_seq_pkg::*;
#(
   parameter int unsigned NRAIL    = 4,
   parameter int unsigned PW       = 2,
   parameter int unsigned STEP_CYC = 8,
   parameter int unsigned TMO_CYC  = 16,
   parameter int unsigned CW       = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NRAIL-1:0][NRAIL-1:0]  pos_mask,
   input  logic [NRAIL-1:0]             tgt_en,
   input  logic                         up_req,
   input  logic                         down_req,
   input  logic                         mode_sw,
   input  logic [NRAIL-1:0]             uv,
   input  logic [CW-1:0]                cnt,
   output logic                         cnt_clr,
   output logic                         cnt_inc,
   output seq_st_e                      st,
   output logic [NRAIL-1:0]             rail_en,
   output logic                         busy,
   output logic                         fault
);

   localparam logic [PW-1:0] LAST     = PW'(NRAIL - 1);
   localparam logic [CW-1:0] STEP_END = CW'(STEP_CYC - 1);
   localparam logic [CW-1:0] TMO_END  = CW'(TMO_CYC - 1);

   seq_st_e          st_q, st_d;
   logic [PW-1:0]    step_q, step_d, step_nx, step_pv;
   logic [NRAIL-1:0] en_q, en_d;
   logic [NRAIL-1:0] tgt_q, tgt_d;
   logic [NRAIL-1:0] new_q, new_d;
   logic             flt_q, flt_d;
   logic             step_done, tmo_done, go_down;

   assign step_nx   = step_q + PW'(1);
   assign step_pv   = step_q - PW'(1);
   assign step_done = (cnt == STEP_END);
   assign tmo_done  = (cnt == TMO_END);

   always_comb begin
      st_d    = st_q;
      step_d  = step_q;
      en_d    = en_q;
      tgt_d   = tgt_q;
      new_d   = new_q;
      flt_d   = flt_q;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      go_down = 1'b0;
      unique case (st_q)
         SQ_OFF: begin
            if (up_req) begin
               st_d    = SQ_RISE;
               step_d  = '0;
               tgt_d   = tgt_en;
               flt_d   = 1'b0;
               en_d    = tgt_en & pos_mask[0];
               cnt_clr = 1'b1;
            end
         end
         SQ_RISE: begin
            if (step_done) begin
               cnt_clr = 1'b1;
               if (step_q == LAST) begin
                  st_d = SQ_SETTLE;
               end else begin
                  step_d = step_nx;
                  en_d   = en_q | (tgt_q & pos_mask[step_nx]);
               end
            end else begin
               cnt_inc = 1'b1;
            end
         end
         SQ_SETTLE: begin
            if ((en_q & uv) == '0) begin
               st_d    = SQ_ON;
               cnt_clr = 1'b1;
            end else if (tmo_done) begin
               flt_d   = 1'b1;
               go_down = 1'b1;
            end else begin
               cnt_inc = 1'b1;
            end
         end
         SQ_ON: begin
            if (down_req) begin
               go_down = 1'b1;
            end else if (mode_sw) begin
               st_d    = SQ_SWAP;
               tgt_d   = tgt_en;
               new_d   = tgt_en & ~en_q;
               en_d    = en_q | tgt_en;
               cnt_clr = 1'b1;
            end
         end
         SQ_SWAP: begin
            if ((new_q & uv) == '0) begin
               st_d    = SQ_ON;
               en_d    = tgt_q;
               cnt_clr = 1'b1;
            end else if (tmo_done) begin
               flt_d   = 1'b1;
               go_down = 1'b1;
            end else begin
               cnt_inc = 1'b1;
            end
         end
         SQ_FALL: begin
            if (step_done) begin
               cnt_clr = 1'b1;
               if (step_q == '0) begin
                  st_d = SQ_OFF;
               end else begin
                  step_d = step_pv;
                  en_d   = en_q & ~pos_mask[step_pv];
               end
            end else begin
               cnt_inc = 1'b1;
            end
         end
         default: begin
            st_d = SQ_OFF;
            en_d = '0;
         end
      endcase
      // power-down starts from the last slot
      if (go_down) begin
         st_d    = SQ_FALL;
         step_d  = LAST;
         cnt_clr = 1'b1;
         cnt_inc = 1'b0;
         en_d    = en_q & ~pos_mask[LAST];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_OFF;
         step_q <= '0;
         en_q   <= '0;
         tgt_q  <= '0;
         new_q  <= '0;
         flt_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         step_q <= step_d;
         en_q   <= en_d;
         tgt_q  <= tgt_d;
         new_q  <= new_d;
         flt_q  <= flt_d;
      end
   end

   assign st      = st_q;
   assign rail_en = en_q;
   assign fault   = flt_q;
   assign busy    = (st_q == SQ_RISE) || (st_q == SQ_SETTLE) ||
                    (st_q == SQ_SWAP) || (st_q == SQ_FALL);

endmodule

// File: rtl/rail_seq_pgood.sv
module rail_seq_pgood #(
   parameter int unsigned NRAIL    = 4,
   parameter bit          OV_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_on,
   input  logic             in_swap,
   input  logic             vchg,
   input  logic             wd_en,
   input  logic             wd_exp,
   input  logic [NRAIL-1:0] rail_en,
   input  logic [NRAIL-1:0] uv,
   input  logic [NRAIL-1:0] ov,
   output logic             sys_rst_n
);

   logic [NRAIL-1:0] bad;
   logic             hold;

   if (OV_CHECK) begin : g_window
      assign bad = rail_en & (uv | ov);
   end else begin : g_low_only
      assign bad = rail_en & uv & ~(ov & ~ov);
   end

   assign hold = (wd_en & wd_exp) |
                 ~(in_on | in_swap) |
                 (in_on & ~vchg & (|bad));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_rst_n <= 1'b0;
      end else begin
         sys_rst_n <= ~hold;
      end
   end

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
   import rail_seq_pkg::*;
#(
   parameter int unsigned NRAIL    = 4,
   parameter int unsigned PW       = (NRAIL > 1) ? $clog2(NRAIL) : 1,
   parameter int unsigned STEP_CYC = 100000,
   parameter int unsigned TMO_CYC  = 250000,
   parameter bit          OV_CHECK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NRAIL*PW-1:0]  pos_cfg,
   input  logic [NRAIL-1:0]     tgt_en,
   input  logic                 up_req,
   input  logic                 down_req,
   input  logic                 mode_sw,
   input  logic [NRAIL-1:0]     uv,
   input  logic [NRAIL-1:0]     ov,
   input  logic                 vchg,
   input  logic                 wd_en,
   input  logic                 wd_exp,
   output logic [NRAIL-1:0]     rail_en,
   output logic                 sys_rst_n,
   output logic                 busy,
   output logic                 seq_fault
);

   localparam int unsigned CW = cnt_width(STEP_CYC, TMO_CYC);

   if (NRAIL < 2) begin : g_chk_nrail
      $error("rail_sequencer: NRAIL must be at least 2");
   end
   if (PW < $clog2(NRAIL)) begin : g_chk_pw
      $error("rail_sequencer: PW too narrow for NRAIL slots");
   end
   if (STEP_CYC < 1 || TMO_CYC < 1) begin : g_chk_time
      $error("rail_sequencer: STEP_CYC and TMO_CYC must be nonzero");
   end

   logic [NRAIL-1:0][NRAIL-1:0] pos_mask;
   logic [CW-1:0]               cnt;
   logic                        cnt_clr, cnt_inc;
   seq_st_e                     st;

   rail_seq_posdec #(.NRAIL(NRAIL), .PW(PW)) u_posdec (
      .pos_cfg  (pos_cfg),
      .pos_mask (pos_mask)
   );

   rail_seq_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (cnt)
   );

   rail_seq_ctrl #(
      .NRAIL    (NRAIL),
      .PW       (PW),
      .STEP_CYC (STEP_CYC),
      .TMO_CYC  (TMO_CYC),
      .CW       (CW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .pos_mask (pos_mask),
      .tgt_en   (tgt_en),
      .up_req   (up_req),
      .down_req (down_req),
      .mode_sw  (mode_sw),
      .uv       (uv),
      .cnt      (cnt),
      .cnt_clr  (cnt_clr),
      .cnt_inc  (cnt_inc),
      .st       (st),
      .rail_en  (rail_en),
      .busy     (busy),
      .fault    (seq_fault)
   );

   rail_seq_pgood #(.NRAIL(NRAIL), .OV_CHECK(OV_CHECK)) u_pgood (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_on     (st == SQ_ON),
      .in_swap   (st == SQ_SWAP),
      .vchg      (vchg),
      .wd_en     (wd_en),
      .wd_exp    (wd_exp),
      .rail_en   (rail_en),
      .uv        (uv),
      .ov        (ov),
      .sys_rst_n (sys_rst_n)
   );

endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk
   import rail_seq_pkg::*;
#(
   parameter int unsigned NRAIL = 4
) (
   input logic             clk,
   input logic             rst_n,
   input seq_st_e          st,
   input logic [NRAIL-1:0] rail_en,
   input logic             sys_rst_n,
   input logic             wd_en,
   input logic             wd_exp,
   input logic             fault
);

   AST_WD_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_en && wd_exp) |=> !sys_rst_n); // R8

   AST_SEQ_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_OFF || st == SQ_RISE || st == SQ_SETTLE || st == SQ_FALL) |=> !sys_rst_n); // R4

   AST_RISE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_RISE) |=> ((~rail_en & $past(rail_en)) == '0)); // R2

   AST_FALL_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_FALL) |=> ((rail_en & ~$past(rail_en)) == '0)); // R3

   AST_SWAP_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_SWAP && $past(st) == SQ_SWAP) |-> (($past(rail_en) & ~rail_en) == '0)); // R7

   AST_FAULT_STARTS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> (st == SQ_FALL)); // R10

endmodule

bind rail_sequencer rail_sequencer_chk #(.NRAIL(NRAIL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st        (st),
   .rail_en   (rail_en),
   .sys_rst_n (sys_rst_n),
   .wd_en     (wd_en),
   .wd_exp    (wd_exp),
   .fault     (seq_fault)
);

// File: tb/rail_sequencer_tb.sv
module rail_sequencer_tb;

   localparam int STEP = 8;
   localparam int TMO  = 24;
   localparam int RAMP = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pos_cfg = 8'h00;
   logic [3:0] tgt_en = 4'h0;
   logic       up_req = 1'b0, down_req = 1'b0, mode_sw = 1'b0;
   logic [3:0] ov = 4'h0;
   logic       vchg = 1'b0, wd_en = 1'b0, wd_exp = 1'b0;
   logic [3:0] ramp_uv = 4'hF, stuck = 4'h0, glitch = 4'h0;
   logic [3:0] uv;
   logic [3:0] rail_en;
   logic       sys_rst_n, busy, seq_fault;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   string cur = "R1";
   int rcnt [4];

   assign uv = ramp_uv | stuck | glitch;

   always #10 clk = ~clk;

   rail_sequencer #(.STEP_CYC(STEP), .TMO_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .pos_cfg(pos_cfg), .tgt_en(tgt_en),
      .up_req(up_req), .down_req(down_req), .mode_sw(mode_sw),
      .uv(uv), .ov(ov), .vchg(vchg), .wd_en(wd_en), .wd_exp(wd_exp),
      .rail_en(rail_en), .sys_rst_n(sys_rst_n), .busy(busy), .seq_fault(seq_fault)
   );

   // ---------------- reference model ----------------
   localparam int PH_OFF = 0, PH_UP = 1, PH_CHK = 2, PH_ON = 3, PH_MSW = 4, PH_DN = 5;
   int       m_ph = PH_OFF;
   int       m_step = 0, m_cnt = 0;
   bit [3:0] m_en = 0, m_tgt = 0, m_new = 0;
   bit       m_rst = 0, m_fault = 0;

   function automatic bit [3:0] at_slot(int k);
      bit [3:0] m;
      m = 0;
      for (int r = 0; r < 4; r++) if (int'(pos_cfg[2*r +: 2]) == k) m[r] = 1'b1;
      return m;
   endfunction

   function void m_go_down();
      m_ph = PH_DN; m_step = 3; m_cnt = 0;
      m_en = m_en & ~at_slot(3);
   endfunction

   always @(posedge clk) begin
      bit anybad, hold;
      if (!rst_n) begin
         m_ph = PH_OFF; m_en = 0; m_rst = 0; m_fault = 0; m_cnt = 0; m_step = 0;
      end else begin
         anybad = 1'b0;
         for (int r = 0; r < 4; r++) if (m_en[r] && (uv[r] || ov[r])) anybad = 1'b1;
         hold = (wd_en && wd_exp) || !(m_ph == PH_ON || m_ph == PH_MSW) ||
                (m_ph == PH_ON && !vchg && anybad);
         case (m_ph)
            PH_OFF: if (up_req) begin
               m_tgt = tgt_en; m_fault = 0; m_step = 0; m_cnt = 0;
               m_en = tgt_en & at_slot(0); m_ph = PH_UP;
            end
            PH_UP: begin
               m_cnt++;
               if (m_cnt == STEP) begin
                  m_cnt = 0;
                  if (m_step == 3) m_ph = PH_CHK;
                  else begin m_step++; m_en = m_en | (m_tgt & at_slot(m_step)); end
               end
            end
            PH_CHK: begin
               if ((m_en & uv) == 0) begin m_ph = PH_ON; m_cnt = 0; end
               else begin m_cnt++; if (m_cnt == TMO) begin m_fault = 1; m_go_down(); end end
            end
            PH_ON: begin
               if (down_req) m_go_down();
               else if (mode_sw) begin
                  m_new = tgt_en & ~m_en; m_tgt = tgt_en; m_en = m_en | tgt_en;
                  m_cnt = 0; m_ph = PH_MSW;
               end
            end
            PH_MSW: begin
               if ((m_new & uv) == 0) begin m_en = m_tgt; m_ph = PH_ON; m_cnt = 0; end
               else begin m_cnt++; if (m_cnt == TMO) begin m_fault = 1; m_go_down(); end end
            end
            default: begin
               m_cnt++;
               if (m_cnt == STEP) begin
                  m_cnt = 0;
                  if (m_step == 0) m_ph = PH_OFF;
                  else begin m_step--; m_en = m_en & ~at_slot(m_step); end
               end
            end
         endcase
         m_rst = !hold;
      end
   end

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison and regulator ramp model
   always @(negedge clk) begin
      if (rst_n) begin
         bit m_busy;
         m_busy = (m_ph == PH_UP || m_ph == PH_CHK || m_ph == PH_MSW || m_ph == PH_DN);
         check(cur, "model rail_en", 32'(rail_en), 32'(m_en));
         check(cur, "model sys_rst_n", 32'(sys_rst_n), 32'(m_rst));
         check(cur, "model busy", 32'(busy), 32'(m_busy));
         check(cur, "model fault", 32'(seq_fault), 32'(m_fault));
      end
      for (int r = 0; r < 4; r++) begin
         if (!rail_en[r]) begin rcnt[r] = 0; ramp_uv[r] = 1'b1; end
         else if (rcnt[r] < RAMP) begin rcnt[r]++; ramp_uv[r] = 1'b1; end
         else ramp_uv[r] = 1'b0;
      end
   end

   task automatic pulse_up();
      @(negedge clk); up_req = 1'b1; @(negedge clk); up_req = 1'b0;
   endtask
   task automatic pulse_down();
      @(negedge clk); down_req = 1'b1; @(negedge clk); down_req = 1'b0;
   endtask
   task automatic pulse_mode();
      @(negedge clk); mode_sw = 1'b1; @(negedge clk); mode_sw = 1'b0;
   endtask
   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         if (!busy) break;
         @(negedge clk);
      end
   endtask
   task automatic wait_fault();
      for (int i = 0; i < 3000; i++) begin
         if (seq_fault) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog run did not finish act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < 4; r++) rcnt[r] = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur = "R1";
      check("R1", "rail_en", 32'(rail_en), 0);
      check("R1", "sys_rst_n", 32'(sys_rst_n), 0);
      check("R1", "busy", 32'(busy), 0);
      check("R1", "fault", 32'(seq_fault), 0);

      // slots: rail1=0, rail3=1, rail0=2, rail2=3
      pos_cfg = {2'd1, 2'd3, 2'd0, 2'd2};
      tgt_en  = 4'b1011;
      cur = "R2";
      pulse_up();
      check("R2", "first slot rail", 32'(rail_en), 32'h2);
      cur = "R9";
      pulse_down();
      check("R9", "busy during rise", 32'(busy), 1);
      cur = "R2";
      wait_idle();
      check("R2", "rails after rise", 32'(rail_en), 32'hB);
      cur = "R4";
      @(negedge clk);
      check("R4", "reset released", 32'(sys_rst_n), 1);

      cur = "R5";
      glitch = 4'b0001;
      @(negedge clk); check("R5", "uv enabled rail", 32'(sys_rst_n), 0);
      glitch = 4'b0000;
      @(negedge clk); check("R5", "uv released", 32'(sys_rst_n), 1);
      ov = 4'b1000;
      @(negedge clk); check("R5", "ov enabled rail", 32'(sys_rst_n), 0);
      ov = 4'b0000;
      @(negedge clk);
      glitch = 4'b0100; ov = 4'b0100;
      @(negedge clk); @(negedge clk);
      check("R5", "disabled rail ignored", 32'(sys_rst_n), 1);
      glitch = 4'b0000; ov = 4'b0000;

      cur = "R6";
      vchg = 1'b1; glitch = 4'b0001; ov = 4'b0010;
      @(negedge clk); @(negedge clk);
      check("R6", "masked by vchg", 32'(sys_rst_n), 1);
      glitch = 4'b0000; ov = 4'b0000; vchg = 1'b0;
      @(negedge clk);

      cur = "R8";
      wd_exp = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R8", "expiry without enable", 32'(sys_rst_n), 1);
      wd_en = 1'b1;
      @(negedge clk); check("R8", "watchdog low", 32'(sys_rst_n), 0);
      wd_exp = 1'b0;
      @(negedge clk); check("R8", "watchdog release", 32'(sys_rst_n), 1);
      wd_en = 1'b0;

      cur = "R9";
      pulse_up();
      check("R9", "up ignored when on", 32'(busy), 0);
      check("R9", "rails unchanged", 32'(rail_en), 32'hB);

      cur = "R7";
      tgt_en = 4'b0111;
      pulse_mode();
      check("R7", "union during swap", 32'(rail_en), 32'hF);
      check("R7", "no reset on swap", 32'(sys_rst_n), 1);
      wait_idle();
      check("R7", "old rail dropped", 32'(rail_en), 32'h7);
      @(negedge clk);
      check("R7", "reset high after swap", 32'(sys_rst_n), 1);

      cur = "R11";
      tgt_en = 4'b1111;
      @(negedge clk); down_req = 1'b1; mode_sw = 1'b1;
      @(negedge clk); down_req = 1'b0; mode_sw = 1'b0;
      check("R11", "down wins", 32'(rail_en), 32'h3);
      cur = "R3";
      pulse_up();
      wait_idle();
      check("R3", "all off", 32'(rail_en), 0);
      check("R3", "reset low off", 32'(sys_rst_n), 0);

      cur = "R10";
      stuck = 4'b0001;
      pulse_up();
      wait_fault();
      check("R10", "fault on settle timeout", 32'(seq_fault), 1);
      check("R10", "falling after fault", 32'(busy), 1);
      wait_idle();
      check("R10", "rails off after fault", 32'(rail_en), 0);
      stuck = 4'b0000;
      pulse_up();
      check("R10", "fault cleared by up", 32'(seq_fault), 0);
      wait_idle();
      check("R10", "good restart", 32'(rail_en), 32'hF);
      tgt_en = 4'b0111;
      pulse_mode();
      wait_idle();
      stuck = 4'b1000;
      tgt_en = 4'b1111;
      pulse_mode();
      wait_fault();
      check("R10", "fault on swap timeout", 32'(seq_fault), 1);
      wait_idle();
      check("R10", "off after swap fault", 32'(rail_en), 0);
      stuck = 4'b0000;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule